// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two signed two's complement operands of `WIDTH` bits and produces a signed product of `2*WIDTH` bits. It does this one multiplier bit per clock. Operands enter through a valid/ready handshake. An operation is accepted on a rising edge where both `in_valid` and `in_ready` are high. `in_ready` stays low for the whole time an operation is in flight. An upstream source that holds `in_valid` high during that time is back-pressured: its operands are neither taken nor remembered, and it must keep them until `in_ready` returns.

Inside, the block keeps three things: an accumulator one bit wider than the operands, a shift register that starts out holding the multiplier, and one extra bit that begins at zero. Each step looks at the lowest multiplier bit together with the extra bit below it. Depending on that pair, the step adds the multiplicand to the accumulator, subtracts it, or leaves the accumulator alone. The whole chain then shifts right by one place, and the sign bit is copied into the top. A run of ones in the multiplier therefore costs one subtraction where the run starts and one addition just above where it ends. Negative multipliers come out right without any sign fix-up.

The result side has no back-pressure. A single-cycle `done` pulse marks the cycle in which `product` first shows the new result. `product` then keeps that value until the next operation completes.

Top module: `booth_seq_mult`

## Requirements
- R1: For every pair of `WIDTH`-bit signed operands, the `product` shown with `done` equals their signed product as a `2*WIDTH`-bit two's complement value.
- R2: With `WIDTH` = 4, multiplicand 4'b0111 (7) times multiplier 4'b1101 (-3) yields 8'b11101011 (-21).
- R3: Operands equal to the most negative value, such as -8 with `WIDTH` = 4, give the correct product. For example, -8 times -8 gives 64 and -8 times -1 gives 8, with no overflow in the accumulator.
- R4: `done` is high in the cycle that follows exactly `WIDTH` rising edges after the edge that accepts an operation.
- R5: `done` is high for one cycle per operation, never in two consecutive cycles.
- R6: After an accepted operation, `in_ready` is low until `done` is shown. `in_valid` during that time has no effect: no extra `done` appears and the in-flight result is unchanged.
- R7: `product` changes only in a cycle where `done` is high. It holds its value after `done` until the next operation completes.
- R8: While reset is applied and right after it, `in_ready` is 1, `done` is 0 and `product` is 0.
- R9: The low bit pair {multiplier bit, bit below it} is decoded as follows: 2'b10 subtracts the multiplicand, 2'b01 adds it, and 2'b00 or 2'b11 leaves the accumulator unchanged. So a multiplier of all ones (-1) yields the negated multiplicand, and a multiplier of zero yields zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are offered |
| in_ready | output | 1 | Block is idle and will take offered operands |
| multiplicand | input | WIDTH | Signed multiplicand |
| multiplier | input | WIDTH | Signed multiplier |
| done | output | 1 | One-cycle pulse: new product is valid |
| product | output | 2*WIDTH | Signed product, held between completions |

## Verification
The bench builds the block with `WIDTH` = 4. At that width all 256 operand pairs can be run through the scoreboard, so every bit-pair sequence the recoder can see is covered, including both ends of the signed range. The most negative multiplicand is the case that needs the extra accumulator bit. The same width also makes the worked 7 × -3 case a literal check. A short run keeps `in_valid` high while the block is busy, to show that the back-pressure holds.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Action chosen by one radix-2 recoding step.
  typedef enum logic [1:0] {
    BOOTH_SKIP = 2'd0,
    BOOTH_ADD  = 2'd1,
    BOOTH_SUB  = 2'd2
  } booth_op_e;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
(
  input  logic      cur_bit,
  input  logic      prev_bit,
  output booth_op_e op
);

  // Pair {current, previous}: 10 starts a run of ones (subtract),
  // 01 ends a run (add), 00 and 11 are inside a run or outside one.
  always_comb begin
    unique case ({cur_bit, prev_bit})
      2'b10:   op = BOOTH_SUB;
      2'b01:   op = BOOTH_ADD;
      default: op = BOOTH_SKIP;
    endcase
  end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int AW = WIDTH + 1
) (
  input  logic [AW-1:0]    acc,
  input  logic [WIDTH-1:0] mcand,
  input  booth_op_e        op,
  output logic [AW-1:0]    sum
);

  logic [AW-1:0] mcand_ext;

  // One guard bit keeps the subtraction of the most negative value exact.
  assign mcand_ext = {mcand[WIDTH-1], mcand};

  always_comb begin
    unique case (op)
      BOOTH_ADD: sum = acc + mcand_ext;
      BOOTH_SUB: sum = acc + ~mcand_ext + AW'(1);
      default:   sum = acc;
    endcase
  end

endmodule

// File: rtl/booth_step_ctr.sv
module booth_step_ctr #(
  parameter int STEPS = 8,
  localparam int CW = $clog2(STEPS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic step,
  output logic last
);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (load) begin
      count_q <= '0;
    end else if (step) begin
      count_q <= count_q + CW'(1);
    end
  end

  assign last = (count_q == CW'(STEPS - 1));

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import booth_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int AW = WIDTH + 1,
  localparam int PW = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] multiplicand,
  input  logic [WIDTH-1:0] multiplier,
  output logic             done,
  output logic [PW-1:0]    product
);

  logic             busy_q;
  logic [AW-1:0]    acc_q;
  logic [WIDTH-1:0] mq_q;
  logic             guard_q;
  logic [WIDTH-1:0] mcand_q;
  logic             done_q;
  logic [PW-1:0]    prod_q;

  booth_op_e        step_op;
  logic [AW-1:0]    acc_sum;
  logic [AW-1:0]    acc_shift;
  logic [WIDTH-1:0] mq_shift;
  logic             accept;
  logic             last_step;

  assign accept = in_valid && !busy_q;

  booth_recoder u_recoder (
    .cur_bit  (mq_q[0]),
    .prev_bit (guard_q),
    .op       (step_op)
  );

  booth_addsub #(.WIDTH(WIDTH)) u_addsub (
    .acc   (acc_q),
    .mcand (mcand_q),
    .op    (step_op),
    .sum   (acc_sum)
  );

  booth_step_ctr #(.STEPS(WIDTH)) u_ctr (
    .clk  (clk),
    .rst  (rst),
    .load (accept),
    .step (busy_q),
    .last (last_step)
  );

  // Arithmetic right shift across accumulator, multiplier and guard bit.
  assign acc_shift = {acc_sum[AW-1], acc_sum[AW-1:1]};
  assign mq_shift  = {acc_sum[0], mq_q[WIDTH-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      acc_q   <= '0;
      mq_q    <= '0;
      guard_q <= 1'b0;
      mcand_q <= '0;
      done_q  <= 1'b0;
      prod_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        acc_q   <= '0;
        mq_q    <= multiplier;
        guard_q <= 1'b0;
        mcand_q <= multiplicand;
      end else if (busy_q) begin
        acc_q   <= acc_shift;
        mq_q    <= mq_shift;
        guard_q <= mq_q[0];
        if (last_step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          prod_q <= {acc_shift[WIDTH-1:0], mq_shift};
        end
      end
    end
  end

  assign in_ready = !busy_q;
  assign done     = done_q;
  assign product  = prod_q;

endmodule

// File: rtl/booth_seq_mult_chk.sv
module booth_seq_mult_chk #(
  parameter int WIDTH = 8,
  localparam int PW = 2 * WIDTH,
  localparam int CW = $clog2(WIDTH + 2)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] multiplicand,
  input logic [WIDTH-1:0] multiplier,
  input logic             done,
  input logic [PW-1:0]    product
);

  logic          run_q;
  logic [CW-1:0] gap_q;
  logic [PW-1:0] want_q;
  logic [PW-1:0] a_ext;
  logic [PW-1:0] b_ext;

  assign a_ext = {{WIDTH{multiplicand[WIDTH-1]}}, multiplicand};
  assign b_ext = {{WIDTH{multiplier[WIDTH-1]}}, multiplier};

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      gap_q  <= '0;
      want_q <= '0;
    end else if (in_valid && in_ready) begin
      run_q  <= 1'b1;
      gap_q  <= '0;
      want_q <= a_ext * b_ext;
    end else if (done) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      gap_q <= gap_q + CW'(1);
    end
  end

  // R1, R3, R9: result matches the signed product of the accepted operands
  a_r1_product_ok: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_q && product == want_q));

  // R4: completion exactly WIDTH steps after acceptance
  a_r4_step_count: assert property (@(posedge clk) disable iff (rst)
    done |-> (gap_q == CW'(WIDTH)));

  // R5: single-cycle completion pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: busy after acceptance
  a_r6_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R6: not ready while an operation runs and has not finished
  a_r6_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (run_q && !done) |-> !in_ready);

  // R7: product only moves with done
  a_r7_product_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(product));

  // R8: reset values right after reset
  a_r8_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_ready && !done && product == '0));

endmodule

bind booth_seq_mult booth_seq_mult_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/booth_seq_mult_bench.sv
module booth_seq_mult_bench;

  localparam int W = 4;
  localparam int PW = 2 * W;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  multiplicand = '0;
  logic [W-1:0]  multiplier = '0;
  logic          done;
  logic [PW-1:0] product;

  int checks = 0;
  int failures = 0;
  int unsigned cyc = 0;
  logic finished = 1'b0;

  typedef struct {
    logic [PW-1:0] prod;
    int unsigned   due;
    string         tag;
  } exp_t;

  exp_t sb[$];
  logic [PW-1:0] last_prod = '0;
  logic          prev_done = 1'b0;

  booth_seq_mult #(.WIDTH(W)) u_booth_seq_mult (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .done         (done),
    .product      (product)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [PW-1:0] smul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [PW-1:0] ae, be;
    ae = {{W{a[W-1]}}, a};
    be = {{W{b[W-1]}}, b};
    return ae * be;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Driver: offers one operation and records what the scoreboard should see.
  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    exp_t e;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    multiplicand = a;
    multiplier = b;
    e.prod = smul(a, b);
    e.due = cyc + 1 + W;
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: pops expectations as results appear.
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        check(!prev_done, "R5 done pulse", PW'(prev_done), '0);
        if (sb.size() == 0) begin
          check(1'b0, "R6 unexpected done", product, '0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(product == e.prod, e.tag, product, e.prod);
          check(cyc == e.due, "R4 latency", PW'(cyc), PW'(e.due));
        end
        last_prod = product;
      end else begin
        check(product == last_prod, "R7 product hold", product, last_prod);
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R8 ready in reset", PW'(in_ready), PW'(1));
    check(done == 1'b0, "R8 done in reset", PW'(done), '0);
    check(product == '0, "R8 product in reset", product, '0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1 && done == 1'b0, "R8 after reset", PW'({in_ready, done}), PW'(2));

    // Worked case first
    send(4'b0111, 4'b1101, "R2 7 x -3");
    while (sb.size() != 0) @(negedge clk);
    check(product == 8'b11101011, "R2 literal -21", product, 8'b11101011);

    // Extremes and recoding corners
    send(4'b1000, 4'b1000, "R3 -8 x -8");
    send(4'b1000, 4'b1111, "R3 -8 x -1");
    send(4'b0111, 4'b1000, "R3 7 x -8");
    send(4'b0101, 4'b1111, "R9 all-ones multiplier");
    send(4'b0110, 4'b0000, "R9 zero multiplier");
    send(4'b0011, 4'b0101, "R9 alternating bits");

    // Back-pressure: hold valid high with other operands while busy
    send(4'b1011, 4'b0110, "R6 in-flight result");
    in_valid = 1'b1;
    multiplicand = 4'b0111;
    multiplier = 4'b0111;
    for (int k = 1; k < W; k++) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R6 ready low while busy", PW'(in_ready), '0);
    end
    in_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    check(product == smul(4'b1011, 4'b0110), "R7 held after done", product,
          smul(4'b1011, 4'b0110));

    // Exhaustive sweep
    for (int i = 0; i < (1 << W); i++) begin
      for (int j = 0; j < (1 << W); j++) begin
        send(W'(i), W'(j), "R1 sweep");
      end
    end
    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R6 no leftover", PW'(sb.size()), '0);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired, pending=%0d", sb.size());
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule